// File: doc/BRIEF.md
# DDR Read Burst Output Sequencer

This block forms the read data path on the memory side of a double-data-rate SDRAM. It samples read commands on the rising clock edge. Each command carries a bank, a starting column and an auto-precharge flag. After the programmed CAS latency, the block drives the burst as a stream of data elements with a matching data strobe. To keep the logic on a single clock, every cycle is presented as two halves. There is a rise-half word and a fall-half word, a two-bit strobe value and two-bit output enables for data and strobe. A low enable stands for high impedance on that half.

Mode settings are latched through a small write port: CAS latency 2 or 2.5, burst length 2, 4 or 8, and sequential or interleaved order. Every later read uses the latched settings. Reads may follow each other on any rising edge. A later read either continues the stream without a gap or cuts the earlier burst short. A preamble appears only where a stream starts. The strobe is released where the stream stops. A small tracker records, per bank, when a row was activated. It raises a one-cycle flag when an auto-precharge begins, and it holds the flag back until the minimum row-active time has passed.

Top module: `ddr_rd_seq`

## Requirements
- R1: In reset, and in the first cycle after reset, all data and strobe enables and every auto-precharge flag are low.
- R2: A read sampled at rising edge t puts its first element in the rise half of the cycle that follows edge t+2 when mode_cl_half is 0 (CL 2). When mode_cl_half is 1 (CL 2.5), the first element is in the fall half of that cycle. mode_bl holds log2 of the burst length: 1, 2 or 3 select 2, 4 or 8 elements.
- R3: Element k of a burst carries the data word {rd_bank, column}, zero-extended. The column keeps every bit of the starting column above the burst-length-aligned block. Its low bits are (offset + k) mod BL when mode_ilv is 0, or offset XOR k when mode_ilv is 1, where offset is the starting column modulo BL.
- R4: Elements leave two per cycle, one per half. The strobe is enabled on every half that carries data. It is 1 on even-numbered elements and 0 on odd-numbered ones, so the last element of a burst coincides with a low strobe.
- R5: When no data is being driven in the two halves before the first element of a read, the strobe is driven low in both of those halves (preamble) and the data enable stays low there.
- R6: In any half that carries no element and no preamble, both the data enable and the strobe enable are low.
- R7: A read issued BL/2 cycles after the previous read makes its first element follow the previous burst's last element in the very next half, with no preamble.
- R8: A read issued fewer than BL/2 cycles after the previous read cuts that burst short. The new first element sits in the half where R2 places it, and the earlier burst's later elements never appear.
- R9: Let a read with rd_ap set complete at edge C: the edge at which its last pair of elements is launched, or the edge at which the truncating read is taken over. Let its bank's last activation be sampled at edge A. Then ap_start[bank] is high for exactly one cycle, the cycle after edge max(C+1, A+TRAS+1).
- R10: When two streams are one cycle apart, the preamble of the second fills the gap and the strobe stays enabled. With a longer gap, the strobe is released in between and a fresh preamble precedes the second burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Latch the three mode fields below |
| mode_cl_half | input | 1 | 0: CAS latency 2, 1: CAS latency 2.5 |
| mode_bl | input | 2 | log2 of burst length (1, 2, 3) |
| mode_ilv | input | 1 | 0: sequential order, 1: interleaved order |
| act_v | input | 1 | Row activation seen on this edge |
| act_bank | input | BANKW | Bank of the activation |
| rd_v | input | 1 | Read command on this edge |
| rd_bank | input | BANKW | Bank of the read |
| rd_col | input | COLW | Starting column of the read |
| rd_ap | input | 1 | Auto-precharge after this burst |
| dq_rise | output | DW | Data word of the rise half |
| dq_fall | output | DW | Data word of the fall half |
| dq_oe | output | 2 | Data enable, bit 0 rise half, bit 1 fall half |
| dqs_val | output | 2 | Strobe level, bit 0 rise half, bit 1 fall half |
| dqs_oe | output | 2 | Strobe enable, bit 0 rise half, bit 1 fall half |
| ap_start | output | 2**BANKW | One-cycle flag per bank: auto-precharge begins |

## Verification
Suppose the burst engine held a wrong beat count or a stale command. The data word in the affected half would then show a wrong column, or an enable would sit high or low in the wrong half. This shows up in the first cycle that the faulty pair is launched, two edges after the read. A broken half-cycle shifter shifts the whole stream by one half. That is visible on the first element of any CAS latency 2.5 burst. A wrong row-active counter moves the auto-precharge flag away from its computed cycle, which is found at the first auto-precharge read.

// File: rtl/ddr_rd_pkg.sv
// Shared types and helpers for the DDR read output sequencer.
// Assumes burst lengths of 2, 4 and 8 only (at most four element pairs).
package ddr_rd_pkg;

    // Latched mode settings used by every read.
    typedef struct packed {
        logic       cl_half;   // 1: half-cycle extra latency
        logic [1:0] bl_log2;   // 1, 2 or 3
        logic       ilv;       // 1: interleaved order
    } rd_mode_t;

    // Index of the last element pair of a burst for a given length code.
    function automatic logic [1:0] last_pair(input logic [1:0] bl_log2);
        case (bl_log2)
            2'd2:    return 2'd1;
            2'd3:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ddr_rd_engine.sv
// Mode latch, command stage and burst engine on the CAS-latency-2 grid.
// The engine produces one element pair per cycle, plus a preamble marker.
// A read that arrives while a burst runs takes over at once, so a later
// read splices onto or truncates the running burst.
// Assumes COLW >= 3 and DW >= BANKW + COLW. The mode is written only
// while no read is in flight.
module ddr_rd_engine
    import ddr_rd_pkg::*;
#(
    parameter int DW    = 16,
    parameter int COLW  = 10,
    parameter int BANKW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic             mode_cl_half,
    input  logic [1:0]       mode_bl,
    input  logic             mode_ilv,
    input  logic             rd_v,
    input  logic [BANKW-1:0] rd_bank,
    input  logic [COLW-1:0]  rd_col,
    input  logic             rd_ap,
    output logic             cl_half,
    output logic             g_dv,
    output logic             g_pre,
    output logic [DW-1:0]    g_rise,
    output logic [DW-1:0]    g_fall,
    output logic             done_v,
    output logic [BANKW-1:0] done_bank,
    output logic             done_ap
);

    rd_mode_t mode_q;

    logic             a_v;
    logic [BANKW-1:0] a_bank;
    logic [COLW-1:0]  a_col;
    logic             a_ap;

    logic             busy;
    logic [BANKW-1:0] e_bank;
    logic [COLW-1:0]  e_col;
    logic             e_ap;
    logic [1:0]       e_bl;
    logic             e_ilv;
    logic [1:0]       beat;
    logic [1:0]       e_last;
    logic             at_end;
    logic [DW-1:0]    w0;
    logic [DW-1:0]    w1;

    // Column of element k inside the burst-length-aligned block.
    function automatic logic [COLW-1:0] burst_col(
        input logic [COLW-1:0] c,
        input logic [1:0]      bl,
        input logic            il,
        input logic [2:0]      k
    );
        logic [2:0]      m;
        logic [2:0]      o;
        logic [2:0]      off;
        logic [COLW-1:0] r;
        m        = 3'((4'd1 << bl) - 4'd1);
        o        = c[2:0] & m;
        off      = il ? (o ^ k) : ((o + k) & m);
        r        = c;
        r[2:0]   = (c[2:0] & ~m) | (off & m);
        return r;
    endfunction

    assign cl_half   = mode_q.cl_half;
    assign e_last    = last_pair(e_bl);
    assign at_end    = busy && (beat == e_last);
    assign done_v    = busy && (at_end || a_v);
    assign done_bank = e_bank;
    assign done_ap   = e_ap;
    assign w0 = DW'({e_bank, burst_col(e_col, e_bl, e_ilv, {1'b0, beat, 1'b0})});
    assign w1 = DW'({e_bank, burst_col(e_col, e_bl, e_ilv, {1'b0, beat, 1'b1})});

    // Mode register: latch settings, normalising length code 0 to 2 elements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '{cl_half: 1'b0, bl_log2: 2'd2, ilv: 1'b0};
        end else if (mode_we) begin
            mode_q <= '{cl_half: mode_cl_half,
                        bl_log2: (mode_bl == 2'd0) ? 2'd1 : mode_bl,
                        ilv:     mode_ilv};
        end
    end

    // Command stage: register the read sampled on this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_v    <= 1'b0;
            a_bank <= '0;
            a_col  <= '0;
            a_ap   <= 1'b0;
        end else begin
            a_v    <= rd_v;
            a_bank <= rd_bank;
            a_col  <= rd_col;
            a_ap   <= rd_ap;
        end
    end

    // Burst engine: take over a new read, else advance or finish the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            e_bank <= '0;
            e_col  <= '0;
            e_ap   <= 1'b0;
            e_bl   <= 2'd1;
            e_ilv  <= 1'b0;
            beat   <= '0;
        end else if (a_v) begin
            busy   <= 1'b1;
            e_bank <= a_bank;
            e_col  <= a_col;
            e_ap   <= a_ap;
            e_bl   <= mode_q.bl_log2;
            e_ilv  <= mode_q.ilv;
            beat   <= '0;
        end else if (at_end) begin
            busy   <= 1'b0;
        end else if (busy) begin
            beat   <= beat + 2'd1;
        end
    end

    // Pair launch: emit the current pair, or mark a preamble cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_dv   <= 1'b0;
            g_pre  <= 1'b0;
            g_rise <= '0;
            g_fall <= '0;
        end else begin
            g_dv   <= busy;
            g_pre  <= a_v && !busy;
            g_rise <= busy ? w0 : '0;
            g_fall <= busy ? w1 : '0;
        end
    end

    // R5: a preamble cycle is always followed by data.
    assert_pre_then_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        g_pre |=> g_dv);

    // R3: the beat never runs past the last pair of the burst.
    assert_beat_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (beat <= e_last));

endmodule

// File: rtl/ddr_rd_phase.sv
// Maps the CAS-latency-2 pair stream onto the output halves.
// For CAS latency 2.5 the stream is delayed by one half cycle: the rise half
// carries the previous cycle's fall element and the fall half carries the
// current rise element.
// Assumes cl_half is static while a stream is running.
module ddr_rd_phase #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cl_half,
    input  logic          g_dv,
    input  logic          g_pre,
    input  logic [DW-1:0] g_rise,
    input  logic [DW-1:0] g_fall,
    output logic [DW-1:0] dq_rise,
    output logic [DW-1:0] dq_fall,
    output logic [1:0]    dq_oe,
    output logic [1:0]    dqs_val,
    output logic [1:0]    dqs_oe
);

    logic          p_dv;
    logic          p_sv;
    logic [DW-1:0] p_fall;
    logic          g_sv;

    assign g_sv = g_dv | g_pre;

    // Hold the fall half of the previous cycle for the half-cycle shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_dv   <= 1'b0;
            p_sv   <= 1'b0;
            p_fall <= '0;
        end else begin
            p_dv   <= g_dv;
            p_sv   <= g_sv;
            p_fall <= g_fall;
        end
    end

    // Select aligned or half-shifted halves by CAS latency.
    always_comb begin
        if (cl_half) begin
            dq_rise = p_fall;
            dq_fall = g_rise;
            dq_oe   = {g_dv, p_dv};
            dqs_oe  = {g_sv, p_sv};
            dqs_val = {g_dv, 1'b0};
        end else begin
            dq_rise = g_rise;
            dq_fall = g_fall;
            dq_oe   = {g_dv, g_dv};
            dqs_oe  = {g_sv, g_sv};
            dqs_val = {1'b0, g_dv};
        end
    end

    // R4: the strobe is enabled on every half that carries data.
    assert_strobe_with_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe[0] |-> dqs_oe[0]) and (dq_oe[1] |-> dqs_oe[1]));

    // R4: strobe level follows element parity (even high, odd low).
    assert_strobe_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe[0] |-> (dqs_val[0] == !cl_half)) and (dq_oe[1] |-> (dqs_val[1] == cl_half)));

endmodule

// File: rtl/ddr_rd_ap_track.sv
// Per-bank auto-precharge tracker. It counts cycles since each bank's row
// activation, saturating at TRAS. It records a pending auto-precharge when
// a flagged burst completes and pulses ap_start once the row-active time
// is met.
// Assumes at most one completion per cycle (one burst engine).
module ddr_rd_ap_track #(
    parameter int BANKW = 2,
    parameter int TRAS  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  act_v,
    input  logic [BANKW-1:0]      act_bank,
    input  logic                  done_v,
    input  logic [BANKW-1:0]      done_bank,
    input  logic                  done_ap,
    output logic [2**BANKW-1:0]   ap_start
);

    localparam int NBANK = 2 ** BANKW;
    localparam int CW    = $clog2(TRAS + 1);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [CW-1:0] cnt;
        logic          pend;
        logic          fire;
        logic          fire_q;
        logic          set;

        assign set  = done_v && done_ap && (done_bank == BANKW'(b));
        assign fire = pend && (cnt >= CW'(TRAS));
        assign ap_start[b] = fire_q;

        // Row-active counter: restart on activation, saturate at TRAS.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (act_v && (act_bank == BANKW'(b))) begin
                cnt <= '0;
            end else if (cnt < CW'(TRAS)) begin
                cnt <= cnt + CW'(1);
            end
        end

        // Pending flag and start pulse: fire once the row-active time is met.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend   <= 1'b0;
                fire_q <= 1'b0;
            end else begin
                pend   <= set | (pend & ~fire);
                fire_q <= fire;
            end
        end

        // R9: a precharge never starts before the row-active time has passed.
        assert_tras_met_R9: assert property (@(posedge clk) disable iff (!rst_n)
            fire_q |-> ($past(cnt) >= CW'(TRAS)));
    end

endmodule

// File: rtl/ddr_rd_seq.sv
// Top of the DDR read burst output sequencer: engine, phase shifter and
// auto-precharge tracker. All outputs are half-cycle pairs on one clock.
module ddr_rd_seq #(
    parameter int DW    = 16,
    parameter int COLW  = 10,
    parameter int BANKW = 2,
    parameter int TRAS  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_we,
    input  logic                mode_cl_half,
    input  logic [1:0]          mode_bl,
    input  logic                mode_ilv,
    input  logic                act_v,
    input  logic [BANKW-1:0]    act_bank,
    input  logic                rd_v,
    input  logic [BANKW-1:0]    rd_bank,
    input  logic [COLW-1:0]     rd_col,
    input  logic                rd_ap,
    output logic [DW-1:0]       dq_rise,
    output logic [DW-1:0]       dq_fall,
    output logic [1:0]          dq_oe,
    output logic [1:0]          dqs_val,
    output logic [1:0]          dqs_oe,
    output logic [2**BANKW-1:0] ap_start
);

    logic             cl_half;
    logic             g_dv;
    logic             g_pre;
    logic [DW-1:0]    g_rise;
    logic [DW-1:0]    g_fall;
    logic             done_v;
    logic [BANKW-1:0] done_bank;
    logic             done_ap;

    ddr_rd_engine #(.DW(DW), .COLW(COLW), .BANKW(BANKW)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_we      (mode_we),
        .mode_cl_half (mode_cl_half),
        .mode_bl      (mode_bl),
        .mode_ilv     (mode_ilv),
        .rd_v         (rd_v),
        .rd_bank      (rd_bank),
        .rd_col       (rd_col),
        .rd_ap        (rd_ap),
        .cl_half      (cl_half),
        .g_dv         (g_dv),
        .g_pre        (g_pre),
        .g_rise       (g_rise),
        .g_fall       (g_fall),
        .done_v       (done_v),
        .done_bank    (done_bank),
        .done_ap      (done_ap)
    );

    ddr_rd_phase #(.DW(DW)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .cl_half (cl_half),
        .g_dv    (g_dv),
        .g_pre   (g_pre),
        .g_rise  (g_rise),
        .g_fall  (g_fall),
        .dq_rise (dq_rise),
        .dq_fall (dq_fall),
        .dq_oe   (dq_oe),
        .dqs_val (dqs_val),
        .dqs_oe  (dqs_oe)
    );

    ddr_rd_ap_track #(.BANKW(BANKW), .TRAS(TRAS)) u_ap (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_v     (act_v),
        .act_bank  (act_bank),
        .done_v    (done_v),
        .done_bank (done_bank),
        .done_ap   (done_ap),
        .ap_start  (ap_start)
    );

endmodule

// File: tb/tb_ddr_rd_seq.sv
// Sweeps every CAS latency, burst length and order. Each configuration runs
// a fixed read pattern (seamless, truncating, one-cycle gap, long gap) and
// compares every half against a model built from the requirements.
module tb_ddr_rd_seq;

    localparam int DW    = 16;
    localparam int COLW  = 10;
    localparam int BANKW = 2;
    localparam int TRAS  = 3;
    localparam int HMAX  = 128;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_we = 1'b0;
    logic             mode_cl_half = 1'b0;
    logic [1:0]       mode_bl = 2'd2;
    logic             mode_ilv = 1'b0;
    logic             act_v = 1'b0;
    logic [BANKW-1:0] act_bank = '0;
    logic             rd_v = 1'b0;
    logic [BANKW-1:0] rd_bank = '0;
    logic [COLW-1:0]  rd_col = '0;
    logic             rd_ap = 1'b0;
    logic [DW-1:0]    dq_rise;
    logic [DW-1:0]    dq_fall;
    logic [1:0]       dq_oe;
    logic [1:0]       dqs_val;
    logic [1:0]       dqs_oe;
    logic [3:0]       ap_start;

    always #2 clk = ~clk;

    ddr_rd_seq #(.DW(DW), .COLW(COLW), .BANKW(BANKW), .TRAS(TRAS)) dut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_cl_half(mode_cl_half),
        .mode_bl(mode_bl), .mode_ilv(mode_ilv), .act_v(act_v), .act_bank(act_bank),
        .rd_v(rd_v), .rd_bank(rd_bank), .rd_col(rd_col), .rd_ap(rd_ap),
        .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe), .dqs_val(dqs_val),
        .dqs_oe(dqs_oe), .ap_start(ap_start)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit fin = 1'b0;

    logic          ev  [HMAX];
    logic [DW-1:0] ed  [HMAX];
    logic          esv [HMAX];
    logic          esl [HMAX];
    string         etag[HMAX];
    logic [3:0]    eap [HMAX/2];
    int rt[5];
    int rb[5];
    int rc[5];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Column of element k (R3), computed arithmetically.
    function automatic int col_of(int c, int blg, int il, int k);
        int bl = 1 << blg;
        int off = c % bl;
        return (c - off) + (il != 0 ? (off ^ k) : ((off + k) % bl));
    endfunction

    // Build expected halves and the auto-precharge cycle for one configuration.
    task automatic build(input int cl, input int blg, input int il);
        int p = 1 << (blg - 1);
        int e;
        int x;
        for (int h = 0; h < HMAX; h++) begin
            ev[h] = 1'b0; ed[h] = '0; esv[h] = 1'b0; esl[h] = 1'b0; etag[h] = "R6 idle";
        end
        for (int s = 0; s < HMAX/2; s++) eap[s] = 4'b0;
        for (int j = 0; j < 5; j++) begin
            int h0 = 2 * (rt[j] + 2) + cl;
            for (int h = h0; h < HMAX; h++) begin
                ev[h] = 1'b0; esv[h] = 1'b0; etag[h] = "R6 idle";
            end
            for (int h = h0 - 2; h < h0; h++) begin
                if (!ev[h]) begin
                    esv[h] = 1'b1; esl[h] = 1'b0; etag[h] = "R5 preamble";
                end
            end
            for (int k = 0; k < 2 * p; k++) begin
                ev[h0 + k]  = 1'b1;
                esv[h0 + k] = 1'b1;
                esl[h0 + k] = ((k % 2) == 0);
                ed[h0 + k]  = DW'((rb[j] << COLW) | col_of(rc[j], blg, il, k));
                case (j)
                    0: etag[h0 + k] = "R2 R3 first burst";
                    1: etag[h0 + k] = "R7 seamless";
                    2: etag[h0 + k] = "R8 truncating";
                    3: etag[h0 + k] = "R10 one-cycle gap";
                    default: etag[h0 + k] = "R10 long gap";
                endcase
            end
        end
        // R9: completion edge of the auto-precharge read, then max with tRAS.
        e = (rt[1] <= rt[0] + p) ? rt[1] + 1 : rt[0] + p + 1;
        x = (e + 1 > 1 + TRAS + 1) ? e + 1 : 1 + TRAS + 1;
        eap[x] = 4'b1000;
    endtask

    // Compare both halves of the current cycle s with the model.
    task automatic check_slot(input int s);
        for (int i = 0; i < 2; i++) begin
            int h = 2 * s + i;
            logic [DW-1:0] w = (i == 0) ? dq_rise : dq_fall;
            chk(dq_oe[i] == ev[h], {etag[h], " dq_oe"}, 32'(dq_oe[i]), 32'(ev[h]));
            if (ev[h]) chk(w == ed[h], {etag[h], " data"}, 32'(w), 32'(ed[h]));
            chk(dqs_oe[i] == esv[h], {etag[h], " dqs_oe"}, 32'(dqs_oe[i]), 32'(esv[h]));
            if (esv[h]) chk(dqs_val[i] == esl[h], "R4 strobe level", 32'(dqs_val[i]), 32'(esl[h]));
        end
        chk(ap_start == eap[s], "R9 ap_start", 32'(ap_start), 32'(eap[s]));
    endtask

    task automatic run_cfg(input int cl, input int blg, input int il, input int cfg);
        int p = 1 << (blg - 1);
        int n;
        rt[0] = 2; rt[1] = 2 + p; rt[2] = rt[1] + 1; rt[3] = rt[2] + p + 1; rt[4] = rt[3] + p + 4;
        rb[0] = 3; rb[1] = 1; rb[2] = 2; rb[3] = 0; rb[4] = 1;
        for (int j = 0; j < 5; j++) rc[j] = (cfg * 37 + j * 29 + 3) % 1024;
        n = rt[4] + p + 6;
        build(cl, blg, il);
        @(negedge clk);
        mode_we = 1'b1; mode_cl_half = cl[0]; mode_bl = blg[1:0]; mode_ilv = il[0];
        @(negedge clk);
        mode_we = 1'b0;
        for (int s = 0; s < n; s++) begin
            @(negedge clk);
            check_slot(s);
            act_v = (s + 1 == 1); act_bank = 2'd3;
            rd_v = 1'b0; rd_ap = 1'b0;
            for (int j = 0; j < 5; j++) begin
                if (rt[j] == s + 1) begin
                    rd_v = 1'b1; rd_bank = rb[j][BANKW-1:0]; rd_col = rc[j][COLW-1:0];
                    rd_ap = (j == 0);
                end
            end
        end
        act_v = 1'b0; rd_v = 1'b0;
    endtask

    initial begin
        int cfg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dq_oe == 2'b00 && dqs_oe == 2'b00, "R1 enables in reset", 32'({dq_oe, dqs_oe}), 32'd0);
        chk(ap_start == 4'b0, "R1 ap_start in reset", 32'(ap_start), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dq_oe == 2'b00 && dqs_oe == 2'b00, "R1 enables after reset", 32'({dq_oe, dqs_oe}), 32'd0);
        chk(ap_start == 4'b0, "R1 ap_start after reset", 32'(ap_start), 32'd0);
        for (int cl = 0; cl < 2; cl++) begin
            for (int blg = 1; blg < 4; blg++) begin
                for (int il = 0; il < 2; il++) begin
                    run_cfg(cl, blg, il, cfg);
                    cfg++;
                end
            end
        end
        fin = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule